// File: doc/BRIEF.md
# Smart-Card Answer-To-Reset Parser

This block follows the Answer-To-Reset stream that a card sends after reset. It takes one byte for each strobe of the receive path. It finds the initial character and reads the format byte. It then follows the chain of interface-byte groups as their presence bits announce them, counts the historical bytes down and takes the final check byte. When the check byte arrives, the parse is finished. The block raises done, and it raises a checksum flag if the exclusive-OR over the frame is not zero.

From the TA byte of the first group it takes the clock-rate index and the baud-adjust index. It looks both up and forms the number of clock cycles per elementary time unit. A bit-level receiver loads this divider once the parse has ended. Every accepted byte is also stored in a capture buffer, which can be read out by index. A synchronous restart input prepares the block for the next card reset.

Top module: `atr_parser`

## Requirements
- R1: While the block waits for the initial character, a strobed byte of value 0x00 is dropped: `byte_count` stays unchanged. The first non-zero byte is stored at index 0.
- R2: The byte after the initial character is the format byte. Its bits 3:0 give the number of historical bytes. Its bits 4, 5, 6 and 7 announce TA, TB, TC and TD of the first group, and the present bytes arrive in that order.
- R3: Each TD byte supplies, in its bits 7:4, the presence bits of the next group. If the TD bit (bit 7) of a group is clear, the interface bytes end there.
- R4: `fi_idx` takes bits 7:4 and `di_idx` takes bits 3:0 of the TA byte of the first group only. A TA byte in a later group leaves both unchanged.
- R5: `div_ok` is high when the current indices give a valid ratio. The F value comes from the table {0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0}, indexed by `fi_idx`. The D value comes from the table {0,1,2,4,8,16,0,0,0,0,2,4,8,16,32,64}, indexed by `di_idx`. The ratio is F/D when `di_idx` < 8 and F*D otherwise. It is valid when F and D are non-zero and the ratio lies in 1..1023. `etu_div` takes this ratio only when the check byte is accepted.
- R6: If the indices give an invalid ratio, `div_ok` is low and `etu_div` keeps its value when the parse ends.
- R7: After reset, `fi_idx` = 1, `di_idx` = 1, `etu_div` = 372, `div_ok` = 1, `done` = 0, `cksum_err` = 0 and `byte_count` = 0.
- R8: If the historical count is zero, the byte after the last interface byte is taken as the check byte.
- R9: `done` goes high in the cycle after the check-byte strobe. After that, further bytes are ignored, so neither `byte_count` nor the buffer changes, until restart.
- R10: `cksum_err` goes high together with `done` if the XOR of all bytes from the format byte through the check byte is not zero.
- R11: Accepted bytes are stored in arrival order and can be read at `rd_byte` for the index on `rd_idx`. `byte_count` stops at 64, and bytes after the 64th are not stored, but the parse goes on.
- R12: `restart` clears `byte_count`, the buffer, `done` and `cksum_err`. It sets `fi_idx`/`di_idx` back to 1 and `etu_div` back to 372, and the next byte is again taken as a candidate initial character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the start of an ATR |
| rx_valid | input | 1 | Strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| rd_idx | input | 6 | Index into the capture buffer |
| rd_byte | output | 8 | Captured byte at rd_idx |
| byte_count | output | 7 | Number of bytes stored |
| done | output | 1 | Check byte received, parse finished |
| cksum_err | output | 1 | Frame XOR not zero |
| fi_idx | output | 4 | Clock-rate index |
| di_idx | output | 4 | Baud-adjust index |
| etu_div | output | 10 | Applied clock cycles per bit |
| div_ok | output | 1 | Current indices give a valid ratio |

## Verification
The parse state is not visible at the ports, so a wrong position in the group chain shows up only in the timing of `done`. Done rises a byte too early or too late, one strobe after the check byte that was really intended. A wrong presence decode also stores a TA value at the wrong time, so `fi_idx`/`di_idx` change in the cycle after an unexpected strobe. A bad XOR accumulator is seen only at the end of the frame, through `cksum_err`. The directed cases therefore check done at the byte before the check byte and at the check byte itself, for chains of several lengths.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [3:0] {
    ST_TS, ST_T0, ST_TA, ST_TB, ST_TC, ST_TD, ST_HIST, ST_TCK, ST_DONE
  } atr_st_e;

  localparam logic [3:0] DEF_IDX = 4'd1;
  localparam logic [9:0] DEF_DIV = 10'd372;
endpackage

// File: rtl/atr_seq.sv
module atr_seq
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       store_en,
  output logic       ta1_en,
  output logic       fin,
  output logic       done,
  output logic       cksum_err
);
  atr_st_e    st, st_n;
  logic [3:0] pres, pres_n;
  logic [3:0] hcnt, hcnt_n;
  logic [7:0] acc, acc_n;
  logic       grp1, grp1_n;
  logic       done_n, err_n;

  // next interface byte after position pos (0 start,1 after TA,2 after TB,3 after TC)
  function automatic atr_st_e pick(input logic [3:0] p, input logic [1:0] pos,
                                   input logic [3:0] h);
    if (pos == 2'd0 && p[0])      return ST_TA;
    else if (pos <= 2'd1 && p[1]) return ST_TB;
    else if (pos <= 2'd2 && p[2]) return ST_TC;
    else if (p[3])                return ST_TD;
    else if (h != 4'd0)           return ST_HIST;
    else                          return ST_TCK;
  endfunction

  always_comb begin
    st_n = st; pres_n = pres; hcnt_n = hcnt; acc_n = acc; grp1_n = grp1;
    done_n = done; err_n = cksum_err;
    store_en = 1'b0; ta1_en = 1'b0; fin = 1'b0;
    if (restart) begin
      st_n = ST_TS; pres_n = '0; hcnt_n = '0; acc_n = '0; grp1_n = 1'b0;
      done_n = 1'b0; err_n = 1'b0;
    end else if (rx_valid) begin
      store_en = (st != ST_DONE) && !(st == ST_TS && rx_byte == 8'h00);
      if (st != ST_TS && st != ST_DONE) acc_n = acc ^ rx_byte;
      case (st)
        ST_TS:   if (rx_byte != 8'h00) st_n = ST_T0;
        ST_T0: begin
          hcnt_n = rx_byte[3:0];
          pres_n = rx_byte[7:4];
          grp1_n = 1'b1;
          st_n   = pick(rx_byte[7:4], 2'd0, rx_byte[3:0]);
        end
        ST_TA: begin
          ta1_en = grp1;
          st_n   = pick(pres, 2'd1, hcnt);
        end
        ST_TB:   st_n = pick(pres, 2'd2, hcnt);
        ST_TC:   st_n = pick(pres, 2'd3, hcnt);
        ST_TD: begin
          pres_n = rx_byte[7:4];
          grp1_n = 1'b0;
          st_n   = pick(rx_byte[7:4], 2'd0, hcnt);
        end
        ST_HIST: begin
          hcnt_n = hcnt - 4'd1;
          if (hcnt == 4'd1) st_n = ST_TCK;
        end
        ST_TCK: begin
          fin    = 1'b1;
          st_n   = ST_DONE;
          done_n = 1'b1;
          err_n  = (acc ^ rx_byte) != 8'h00;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_TS; pres <= '0; hcnt <= '0; acc <= '0; grp1 <= 1'b0;
      done <= 1'b0; cksum_err <= 1'b0;
    end else begin
      st <= st_n; pres <= pres_n; hcnt <= hcnt_n; acc <= acc_n; grp1 <= grp1_n;
      done <= done_n; cksum_err <= err_n;
    end
  end

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |-> done);
  a_r12_restart_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (st == ST_TS && !done && !cksum_err));
  a_r1_zero_ts_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TS && rx_valid && rx_byte == 8'h00 && !restart) |=> st == ST_TS);
endmodule

// File: rtl/atr_ratio.sv
module atr_ratio (
  input  logic [3:0] fi,
  input  logic [3:0] di,
  output logic [9:0] ratio,
  output logic       ok
);
  logic [11:0] f;
  logic [2:0]  sh;
  logic        dv;
  logic [17:0] r;

  always_comb begin
    case (fi)
      4'd1: f = 12'd372;   4'd2: f = 12'd558;   4'd3: f = 12'd744;
      4'd4: f = 12'd1116;  4'd5: f = 12'd1488;  4'd6: f = 12'd1860;
      4'd9: f = 12'd512;   4'd10: f = 12'd768;  4'd11: f = 12'd1024;
      4'd12: f = 12'd1536; 4'd13: f = 12'd2048;
      default: f = 12'd0;
    endcase
    dv = 1'b1;
    case (di)
      4'd1: sh = 3'd0;  4'd2: sh = 3'd1;  4'd3: sh = 3'd2;
      4'd4: sh = 3'd3;  4'd5: sh = 3'd4;
      4'd10: sh = 3'd1; 4'd11: sh = 3'd2; 4'd12: sh = 3'd3;
      4'd13: sh = 3'd4; 4'd14: sh = 3'd5; 4'd15: sh = 3'd6;
      default: begin sh = 3'd0; dv = 1'b0; end
    endcase
    // D is always a power of two: divide or multiply by shifting
    r     = di[3] ? ({6'd0, f} << sh) : ({6'd0, f} >> sh);
    ok    = (f != 12'd0) && dv && (r != 18'd0) && (r < 18'd1024);
    ratio = r[9:0];
  end
endmodule

// File: rtl/atr_store.sv
module atr_store #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);
  logic [7:0] mem [DEPTH];
  logic       room;

  assign room    = count < CW'(DEPTH);
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      count <= '0;
    end else if (restart) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      count <= '0;
    end else if (wr_en && room) begin
      mem[count[IW-1:0]] <= wr_data;
      count <= count + CW'(1);
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !restart) |=> count == CW'(DEPTH));
endmodule

// File: rtl/atr_parser.sv
module atr_parser
  import atr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] byte_count,
  output logic          done,
  output logic          cksum_err,
  output logic [3:0]    fi_idx,
  output logic [3:0]    di_idx,
  output logic [9:0]    etu_div,
  output logic          div_ok
);
  logic       store_en, ta1_en, fin;
  logic [9:0] ratio_now;
  logic [3:0] fi_n, di_n;
  logic [9:0] div_n;

  atr_seq i_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .store_en(store_en), .ta1_en(ta1_en), .fin(fin),
    .done(done), .cksum_err(cksum_err)
  );

  atr_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .restart(restart), .wr_en(store_en),
    .wr_data(rx_byte), .rd_idx(rd_idx), .rd_data(rd_byte), .count(byte_count)
  );

  atr_ratio i_ratio (.fi(fi_idx), .di(di_idx), .ratio(ratio_now), .ok(div_ok));

  always_comb begin
    fi_n = fi_idx; di_n = di_idx; div_n = etu_div;
    if (restart) begin
      fi_n = DEF_IDX; di_n = DEF_IDX; div_n = DEF_DIV;
    end else begin
      if (ta1_en) begin
        fi_n = rx_byte[7:4];
        di_n = rx_byte[3:0];
      end
      if (fin && div_ok) div_n = ratio_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_idx <= DEF_IDX; di_idx <= DEF_IDX; etu_div <= DEF_DIV;
    end else begin
      fi_idx <= fi_n; di_idx <= di_n; etu_div <= div_n;
    end
  end

  a_r5_div_at_end_only: assert property (@(posedge clk) disable iff (!rst_n)
    (etu_div != $past(etu_div)) |-> $past(fin || restart));
  a_r4_idx_from_ta1_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fi_idx != $past(fi_idx) || di_idx != $past(di_idx)) |-> $past(ta1_en || restart));
  a_r9_no_store_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> $stable(byte_count));
endmodule

// File: tb/test_atr_parser.sv
`timescale 1ns/1ps
module test_atr_parser;
  logic       clk = 1'b0;
  logic       rst_n, restart, rx_valid;
  logic [7:0] rx_byte;
  logic [5:0] rd_idx;
  logic [7:0] rd_byte;
  logic [6:0] byte_count;
  logic       done, cksum_err, div_ok;
  logic [3:0] fi_idx, di_idx;
  logic [9:0] etu_div;

  int total = 0;
  int bad = 0;
  int seqb [128];
  bit finished = 0;

  always #2 clk = ~clk;

  atr_parser i_atr_parser (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .byte_count(byte_count), .done(done), .cksum_err(cksum_err),
    .fi_idx(fi_idx), .di_idx(di_idx), .etu_div(etu_div), .div_ok(div_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_ratio(input int fi, input int di);
    int ft [16] = '{0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0};
    int dt [16] = '{0,1,2,4,8,16,0,0,0,0,2,4,8,16,32,64};
    int r;
    if (ft[fi] == 0 || dt[di] == 0) return -1;
    r = (di < 8) ? ft[fi] / dt[di] : ft[fi] * dt[di];
    return (r > 0 && r < 1024) ? r : -1;
  endfunction

  task automatic send(input int b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(b);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_list(input int n);
    for (int i = 0; i < n; i++) send(seqb[i]);
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic rd(input int idx, output int v);
    rd_idx = 6'(idx); #0.5; v = rd_byte;
  endtask

  task automatic t_reset();
    chk("R7 fi", fi_idx, 1); chk("R7 di", di_idx, 1);
    chk("R7 etu", etu_div, 372); chk("R7 ok", div_ok, 1);
    chk("R7 done", done, 0); chk("R7 err", cksum_err, 0);
    chk("R7 count", byte_count, 0);
  endtask

  task automatic t_basic();
    int v;
    send(8'h00); send(8'h00);
    chk("R1 zeros dropped", byte_count, 0);
    send(8'h3B); send(8'h32); send(8'h94); send(8'h00); send(8'h41); send(8'h42);
    chk("R2 not done before check byte", done, 0);
    chk("R4 fi", fi_idx, 9); chk("R4 di", di_idx, 4);
    chk("R5 etu not yet applied", etu_div, 372);
    send(8'hA5);
    chk("R9 done", done, 1); chk("R10 good sum", cksum_err, 0);
    chk("R11 count", byte_count, 7);
    rd(0, v); chk("R1 first stored is TS", v, 8'h3B);
    rd(3, v); chk("R11 order", v, 8'h00);
    rd(6, v); chk("R11 last", v, 8'hA5);
    chk("R5 etu applied", etu_div, ref_ratio(9, 4));
  endtask

  task automatic t_chain();
    int v;
    do_restart();
    send(8'h3B); send(8'h80); send(8'h90); send(8'h11); send(8'h20); send(8'h55);
    chk("R3 not done after chained TB", done, 0);
    chk("R4 later TA ignored fi", fi_idx, 1);
    chk("R4 later TA ignored di", di_idx, 1);
    send(8'h75);
    chk("R8 done with no hist", done, 1);
    chk("R10 bad sum", cksum_err, 1);
    send(8'h99);
    chk("R9 ignored count", byte_count, 7);
    rd(6, v); chk("R9 buffer kept", v, 8'h75);
    chk("R9 done held", done, 1);
  endtask

  task automatic t_muldiv();
    do_restart();
    chk("R12 err cleared", cksum_err, 0);
    send(8'h3B); send(8'h10); send(8'h1A);
    chk("R5 ok mul", div_ok, 1);
    send(8'h0A);
    chk("R5 mul ratio", etu_div, ref_ratio(1, 10));
    chk("R10 ok sum", cksum_err, 0);
  endtask

  task automatic t_invalid();
    do_restart();
    send(8'h3B); send(8'h10); send(8'hD1); send(8'hC1);
    chk("R6 ok low", div_ok, 0);
    chk("R6 etu kept", etu_div, 372);
    chk("R6 fi", fi_idx, 13);
    chk("R6 done", done, 1);
  endtask

  task automatic t_long();
    int n = 0;
    int x = 0;
    int v;
    do_restart();
    seqb[n++] = 8'h3B; seqb[n++] = 8'hFF;
    for (int g = 0; g < 14; g++) begin
      seqb[n++] = (g == 0) ? 8'h11 : (g * 7 + 3) & 8'hFF;
      seqb[n++] = (g * 5 + 1) & 8'hFF;
      seqb[n++] = (g * 3 + 2) & 8'hFF;
      seqb[n++] = (g == 13) ? 8'h00 : 8'hF0;
    end
    for (int h = 0; h < 15; h++) seqb[n++] = 8'h40 + h;
    for (int i = 1; i < n; i++) x ^= seqb[i];
    seqb[n++] = x;
    send_list(n - 1);
    chk("R2 long not done early", done, 0);
    send(seqb[n-1]);
    chk("R11 long done", done, 1);
    chk("R11 long sum", cksum_err, 0);
    chk("R11 saturate", byte_count, 64);
    rd(63, v); chk("R11 64th byte", v, seqb[63]);
  endtask

  task automatic t_restart();
    int v;
    do_restart();
    send(8'h3B); send(8'h10); send(8'h94);
    chk("R12 pre fi", fi_idx, 9);
    do_restart();
    chk("R12 fi", fi_idx, 1); chk("R12 di", di_idx, 1);
    chk("R12 count", byte_count, 0); chk("R12 done", done, 0);
    chk("R12 etu", etu_div, 372);
    rd(0, v); chk("R12 buffer cleared", v, 0);
    send(8'h00);
    chk("R1 zero after restart", byte_count, 0);
    send(8'h3B); send(8'h00); send(8'h00);
    chk("R8 empty ATR done", done, 1);
    chk("R8 empty ATR sum", cksum_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; rx_valid = 1'b0; rx_byte = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_chain();
    t_muldiv();
    t_invalid();
    t_long();
    t_restart();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule